// File: doc/BRIEF.md
# Z80 Mode 0 Interrupt Acknowledge Responder

This block sits beside a Z80 and gives mode 0 interrupts a real purpose. It arbitrates a set of request lines and pulls the CPU interrupt line low when one of them is eligible. When the CPU acknowledges by asserting M1 and IORQ together, the block drives an instruction onto the data bus. It can answer in one of two styles. In restart style it gives a single restart opcode. In call style it gives a three-byte subroutine call to a programmable address. In call style the two address bytes are served on the two memory reads that follow the acknowledge. Whenever the block is disabled or has nothing pending, it leaves the bus alone, so the pull-ups present FFh and the CPU behaves as it would in mode 1.

Software sets the block up through a small synchronous write port. The registers are:

| Address | Contents |
|---|---|
| 0 | control: bit 0 enable, bit 1 call style, bit 2 vector guard |
| 1 | request mask, where a 1 blocks that line |
| 2 | end-of-interrupt: each 1 written clears that line's in-service bit |
| 3 | restart vector base in bits 2:0 |
| 4 | call base address, low byte |
| 5 | call base address, high byte |

The sequencer has six states:

| State | Role |
|---|---|
| IDLE | no sequence running |
| ACK | serving the acknowledge byte |
| WAIT_LO | waiting for the low-byte read |
| DRV_LO | serving the low byte |
| WAIT_HI | waiting for the high-byte read |
| DRV_HI | serving the high byte |

The transitions are:
- IDLE to ACK when a new acknowledge starts while a request is eligible.
- ACK to IDLE (restart style) or to WAIT_LO (call style) when the acknowledge ends.
- WAIT_LO to DRV_LO when a memory read starts.
- DRV_LO to WAIT_HI when that read ends.
- WAIT_HI to DRV_HI when the next memory read starts.
- DRV_HI to IDLE when that read ends.

Top module: `im0_responder`

## Requirements
- R1: After reset, int_n is high, bus_doe is low and the block is disabled.
- R2: int_n goes low one clock after a request is sampled, provided all of these hold: the line is unmasked, the line is not in service, and the block is enabled. A masked line, or a disabled block, leaves int_n high.
- R3: When several lines are eligible, the lowest-numbered line is served first. The other lines keep int_n low after the sequence ends.
- R4: In restart style, the acknowledge read returns binary 11vvv111, where vvv = (line number + vector base) mod 8.
- R5: With the guard bit set and restart style selected, a line whose vector would be 0 or 7 is ignored. It does not pull int_n low and it is not served.
- R6: In call style, the block returns three bytes in order: CDh on the acknowledge read, then the low byte and then the high byte of (call base + 8 × line number) on the next two memory reads. The memory reads are those with MREQ and RD low and M1 high.
- R7: bus_doe is high only while the block serves one of its own bytes inside an acknowledge read or one of its two address reads. An acknowledge that arrives while the block is disabled or has nothing eligible gets no drive. A memory read outside a call sequence also gets no drive.
- R8: The served line becomes in service when the acknowledge starts. A set in-service bit keeps that line from pulling int_n low again. Writing a 1 for that line to the end-of-interrupt register makes it eligible again.
- R9: int_n stays high while a response sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the CPU strobes are synchronous to it |
| rst_n | input | 1 | Active-low reset |
| irq_req | input | NUM_REQ | Level request lines; line 0 has the highest priority |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| m1_n | input | 1 | CPU M1 strobe, active low |
| iorq_n | input | 1 | CPU IORQ strobe, active low |
| mreq_n | input | 1 | CPU MREQ strobe, active low |
| rd_n | input | 1 | CPU RD strobe, active low |
| int_n | output | 1 | Interrupt line to the CPU, active low |
| bus_dout | output | 8 | Byte offered to the data bus; zero when not driving |
| bus_doe | output | 1 | Data bus drive enable |

## Verification
The assertions assume that the CPU strobes are already synchronous to clk. They also assume that an acknowledge, and each of the two address reads, stays active for at least one full clock. The third assumption is that no acknowledge overlaps a memory read. The bench moves every strobe only on falling edges and holds each bus cycle for two clocks. It never overlaps the M1+IORQ pair with the MREQ+RD pair. It also changes the configuration only while the sequencer is idle, so the byte order held by the sequence assertions cannot be disturbed by a style change in mid-sequence.

// File: rtl/im0_pkg.sv
package im0_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ACK,
        S_WAIT_LO,
        S_DRV_LO,
        S_WAIT_HI,
        S_DRV_HI
    } seq_state_t;

    localparam logic [2:0] A_CTRL    = 3'd0;
    localparam logic [2:0] A_MASK    = 3'd1;
    localparam logic [2:0] A_EOI     = 3'd2;
    localparam logic [2:0] A_VBASE   = 3'd3;
    localparam logic [2:0] A_CALL_LO = 3'd4;
    localparam logic [2:0] A_CALL_HI = 3'd5;

    localparam logic [BYTE_W-1:0] OP_CALL = 8'hCD;

    function automatic logic [BYTE_W-1:0] restart_op(input logic [2:0] vec);
        return {2'b11, vec, 3'b111};
    endfunction

endpackage

// File: rtl/im0_cfg_regs.sv
module im0_cfg_regs
    import im0_pkg::*;
#(
    parameter int unsigned NUM_REQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [2:0]         addr,
    input  logic [BYTE_W-1:0]  wdata,
    output logic               en,
    output logic               call_mode,
    output logic               guard,
    output logic [NUM_REQ-1:0] mask,
    output logic [2:0]         vbase,
    output logic [15:0]        call_base,
    output logic               eoi_pulse,
    output logic [NUM_REQ-1:0] eoi_bits
);

    logic unused_wdata;
    assign unused_wdata = &{1'b0, wdata};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en        <= 1'b0;
            call_mode <= 1'b0;
            guard     <= 1'b0;
            mask      <= '0;
            vbase     <= '0;
            call_base <= '0;
        end else if (we) begin
            unique case (addr)
                A_CTRL: begin
                    en        <= wdata[0];
                    call_mode <= wdata[1];
                    guard     <= wdata[2];
                end
                A_MASK:    mask            <= wdata[NUM_REQ-1:0];
                A_VBASE:   vbase           <= wdata[2:0];
                A_CALL_LO: call_base[7:0]  <= wdata;
                A_CALL_HI: call_base[15:8] <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        eoi_pulse = we && (addr == A_EOI);
        eoi_bits  = wdata[NUM_REQ-1:0];
    end

endmodule

// File: rtl/im0_arbiter.sv
module im0_arbiter
    import im0_pkg::*;
#(
    parameter int unsigned NUM_REQ = 4,
    localparam int unsigned IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] irq_req,
    input  logic               en,
    input  logic               call_mode,
    input  logic               guard,
    input  logic [NUM_REQ-1:0] mask,
    input  logic [2:0]         vbase,
    input  logic               busy,
    input  logic               take,
    input  logic               eoi_pulse,
    input  logic [NUM_REQ-1:0] eoi_bits,
    output logic               int_n,
    output logic               win_valid,
    output logic [IW-1:0]      win_idx,
    output logic [2:0]         win_vec
);

    logic [NUM_REQ-1:0] req_q;
    logic [NUM_REQ-1:0] isr_q;
    logic [NUM_REQ-1:0] guarded;
    logic [NUM_REQ-1:0] eligible;
    logic [2:0]         vec_of [NUM_REQ];

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_line
        assign vec_of[g]  = 3'(g) + vbase;
        assign guarded[g] = guard && !call_mode &&
                            ((vec_of[g] == 3'd0) || (vec_of[g] == 3'd7));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= irq_req;
    end

    always_comb begin
        eligible = req_q & ~mask & ~isr_q & ~guarded & {NUM_REQ{en}};
    end

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_vec   = '0;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                win_valid = 1'b1;
                win_idx   = IW'(i);
                win_vec   = vec_of[i];
            end
        end
    end

    always_comb begin
        int_n = !((|eligible) && !busy);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else begin
            isr_q <= (isr_q & ~(eoi_pulse ? eoi_bits : '0)) |
                     (take ? (NUM_REQ'(1) << win_idx) : '0);
        end
    end

    a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ((eligible & ((NUM_REQ'(1) << win_idx) - NUM_REQ'(1))) == '0));

    a_r5_guard_skips_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (guard && !call_mode && win_valid) |-> (win_vec != 3'd0 && win_vec != 3'd7));

    a_r8_take_marks_service: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> isr_q[$past(win_idx)]);

endmodule

// File: rtl/im0_ack_seq.sv
module im0_ack_seq
    import im0_pkg::*;
#(
    parameter int unsigned NUM_REQ = 4,
    localparam int unsigned IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m1_n,
    input  logic              iorq_n,
    input  logic              mreq_n,
    input  logic              rd_n,
    input  logic              win_valid,
    input  logic [IW-1:0]     win_idx,
    input  logic [2:0]        win_vec,
    input  logic              call_mode,
    input  logic [15:0]       call_base,
    output logic              take,
    output logic              busy,
    output logic [BYTE_W-1:0] data_out,
    output logic              data_oe
);

    seq_state_t state_q, state_d;
    logic       ack_live, mrd_live, ack_seen_q;
    logic       call_q;
    logic [BYTE_W-1:0] op_q, lo_q, hi_q;
    logic [15:0] target;

    assign ack_live = !m1_n && !iorq_n;
    assign mrd_live = !mreq_n && !rd_n && m1_n;
    assign target   = call_base + (16'(win_idx) << 3);
    assign take     = (state_q == S_IDLE) && ack_live && !ack_seen_q && win_valid;
    assign busy     = (state_q != S_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (take)      state_d = S_ACK;
            S_ACK:     if (!ack_live) state_d = call_q ? S_WAIT_LO : S_IDLE;
            S_WAIT_LO: if (mrd_live)  state_d = S_DRV_LO;
            S_DRV_LO:  if (!mrd_live) state_d = S_WAIT_HI;
            S_WAIT_HI: if (mrd_live)  state_d = S_DRV_HI;
            S_DRV_HI:  if (!mrd_live) state_d = S_IDLE;
            default:                  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            ack_seen_q <= 1'b0;
            call_q     <= 1'b0;
            op_q       <= '0;
            lo_q       <= '0;
            hi_q       <= '0;
        end else begin
            state_q    <= state_d;
            ack_seen_q <= ack_live;
            if (take) begin
                call_q <= call_mode;
                op_q   <= call_mode ? OP_CALL : restart_op(win_vec);
                lo_q   <= target[7:0];
                hi_q   <= target[15:8];
            end
        end
    end

    always_comb begin
        data_oe  = 1'b0;
        data_out = '0;
        unique case (state_q)
            S_ACK: begin
                data_oe  = ack_live;
                data_out = ack_live ? op_q : '0;
            end
            S_DRV_LO: begin
                data_oe  = mrd_live;
                data_out = mrd_live ? lo_q : '0;
            end
            S_DRV_HI: begin
                data_oe  = mrd_live;
                data_out = mrd_live ? hi_q : '0;
            end
            default: ;
        endcase
    end

    a_r7_drive_inside_read: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (ack_live || mrd_live));

    a_r7_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !data_oe);

    a_r4_restart_form: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && state_q == S_ACK && !call_q) |->
            (data_out[7:6] == 2'b11 && data_out[2:0] == 3'b111));

    a_r6_high_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DRV_HI) |-> ($past(state_q) == S_WAIT_HI || $past(state_q) == S_DRV_HI));

endmodule

// File: rtl/im0_responder.sv
module im0_responder
    import im0_pkg::*;
#(
    parameter int unsigned NUM_REQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] irq_req,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_addr,
    input  logic [7:0]         cfg_wdata,
    input  logic               m1_n,
    input  logic               iorq_n,
    input  logic               mreq_n,
    input  logic               rd_n,
    output logic               int_n,
    output logic [7:0]         bus_dout,
    output logic               bus_doe
);

    localparam int unsigned IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

    logic               en, call_mode, guard, eoi_pulse;
    logic [NUM_REQ-1:0] mask, eoi_bits;
    logic [2:0]         vbase, win_vec;
    logic [15:0]        call_base;
    logic               win_valid, take, busy;
    logic [IW-1:0]      win_idx;

    im0_cfg_regs #(.NUM_REQ(NUM_REQ)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .en(en), .call_mode(call_mode), .guard(guard), .mask(mask), .vbase(vbase),
        .call_base(call_base), .eoi_pulse(eoi_pulse), .eoi_bits(eoi_bits)
    );

    im0_arbiter #(.NUM_REQ(NUM_REQ)) u_arb (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .en(en), .call_mode(call_mode),
        .guard(guard), .mask(mask), .vbase(vbase), .busy(busy), .take(take),
        .eoi_pulse(eoi_pulse), .eoi_bits(eoi_bits), .int_n(int_n),
        .win_valid(win_valid), .win_idx(win_idx), .win_vec(win_vec)
    );

    im0_ack_seq #(.NUM_REQ(NUM_REQ)) u_seq (
        .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .iorq_n(iorq_n), .mreq_n(mreq_n),
        .rd_n(rd_n), .win_valid(win_valid), .win_idx(win_idx), .win_vec(win_vec),
        .call_mode(call_mode), .call_base(call_base), .take(take), .busy(busy),
        .data_out(bus_dout), .data_oe(bus_doe)
    );

    a_r9_int_quiet_in_sequence: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> int_n);

    a_r2_disabled_no_int: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> int_n);

endmodule

// File: tb/tb_im0_responder.sv
module tb_im0_responder;

    localparam int CLK_P = 10;
    localparam int NREQ  = 4;

    typedef struct {
        logic       oe;
        logic [7:0] data;
        string      tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NREQ-1:0] irq_req = '0;
    logic            cfg_we = 1'b0;
    logic [2:0]      cfg_addr = '0;
    logic [7:0]      cfg_wdata = '0;
    logic            m1_n = 1'b1, iorq_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1;
    logic            int_n;
    logic [7:0]      bus_dout;
    logic            bus_doe;

    int   checks = 0;
    int   failures = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];
    event sample_ev;

    always #(CLK_P/2) clk = ~clk;

    im0_responder #(.NUM_REQ(NREQ)) dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .m1_n(m1_n), .iorq_n(iorq_n),
        .mreq_n(mreq_n), .rd_n(rd_n), .int_n(int_n), .bus_dout(bus_dout),
        .bus_doe(bus_doe)
    );

    function automatic logic [7:0] rst_byte(input int line, input int base);
        logic [2:0] v;
        v = 3'((line + base) % 8);
        return {2'b11, v, 3'b111};
    endfunction

    // Monitor: pops one expected bus item per sample event and compares it.
    initial begin
        forever begin
            @(sample_ev);
            if (sb_q.size() == 0) begin
                failures++;
                $display("FAIL monitor: bus sample with no expected item, oe=%0b data=%02h",
                         bus_doe, bus_dout);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (bus_doe !== e.oe || (e.oe && bus_dout !== e.data)) begin
                    failures++;
                    $display("FAIL %s: got oe=%0b data=%02h, expected oe=%0b data=%02h",
                             e.tag, bus_doe, bus_dout, e.oe, e.data);
                end
            end
        end
    end

    task automatic check_int(input logic exp, input string tag);
        checks++;
        if (int_n !== exp) begin
            failures++;
            $display("FAIL %s: int_n=%0b expected %0b", tag, int_n, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_irq(input logic [NREQ-1:0] v);
        @(negedge clk);
        irq_req = v;
        @(negedge clk);
    endtask

    task automatic ack_cycle(input logic oe, input logic [7:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        m1_n = 1'b0; iorq_n = 1'b0;
        e.oe = oe; e.data = d; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        -> sample_ev;
        @(negedge clk);
        m1_n = 1'b1; iorq_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic mem_read(input logic oe, input logic [7:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        mreq_n = 1'b0; rd_n = 1'b0;
        e.oe = oe; e.data = d; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        -> sample_ev;
        @(negedge clk);
        mreq_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        failures++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_int(1'b1, "R1 int idle after reset");
        checks++;
        if (bus_doe !== 1'b0) begin
            failures++;
            $display("FAIL R1 bus_doe=%0b expected 0", bus_doe);
        end
        // R7/R2: disabled block ignores a request and an acknowledge
        set_irq(4'b0001);
        check_int(1'b1, "R2 disabled keeps int high");
        ack_cycle(1'b0, 8'h00, "R7 disabled ack not driven");
        set_irq(4'b0000);

        // Restart style, base 2
        cfg_write(3'd3, 8'd2);
        cfg_write(3'd0, 8'h01);
        set_irq(4'b0100);
        check_int(1'b0, "R2 enabled request raises int");
        ack_cycle(1'b1, rst_byte(2, 2), "R4 restart byte line2");
        check_int(1'b1, "R8 int drops after ack");
        check_int(1'b1, "R8 in-service line stays quiet");
        cfg_write(3'd2, 8'h04);
        @(negedge clk);
        check_int(1'b0, "R8 EOI re-arms line");
        ack_cycle(1'b1, rst_byte(2, 2), "R4 restart byte line2 again");
        set_irq(4'b0000);
        cfg_write(3'd2, 8'h0F);

        // R3: priority
        set_irq(4'b1010);
        check_int(1'b0, "R3 two pending raise int");
        ack_cycle(1'b1, rst_byte(1, 2), "R3 line1 first");
        check_int(1'b0, "R3 line3 still pending");
        ack_cycle(1'b1, rst_byte(3, 2), "R3 line3 second");
        check_int(1'b1, "R3 all in service");
        set_irq(4'b0000);
        cfg_write(3'd2, 8'h0F);

        // R2: masking
        cfg_write(3'd1, 8'h01);
        set_irq(4'b0001);
        check_int(1'b1, "R2 masked line quiet");
        ack_cycle(1'b0, 8'h00, "R7 masked ack not driven");
        cfg_write(3'd1, 8'h00);
        @(negedge clk);
        check_int(1'b0, "R2 unmask raises int");
        ack_cycle(1'b1, rst_byte(0, 2), "R4 restart byte line0");
        set_irq(4'b0000);
        cfg_write(3'd2, 8'h0F);

        // R5: guard, base 7 (line0->7, line1->0 blocked)
        cfg_write(3'd3, 8'd7);
        cfg_write(3'd0, 8'h05);
        set_irq(4'b0011);
        check_int(1'b1, "R5 guarded vectors ignored");
        ack_cycle(1'b0, 8'h00, "R5 guarded ack not driven");
        set_irq(4'b0111);
        check_int(1'b0, "R5 usable line raises int");
        ack_cycle(1'b1, rst_byte(2, 7), "R5 line2 vector 1");
        set_irq(4'b0000);
        cfg_write(3'd2, 8'h0F);
        cfg_write(3'd0, 8'h01);
        set_irq(4'b0001);
        ack_cycle(1'b1, rst_byte(0, 7), "R4 unguarded vector 7 gives FF");
        set_irq(4'b0000);
        cfg_write(3'd2, 8'h0F);

        // R6: call style, base 1230h, line2 -> 1240h
        cfg_write(3'd4, 8'h30);
        cfg_write(3'd5, 8'h12);
        cfg_write(3'd0, 8'h03);
        set_irq(4'b0110);
        ack_cycle(1'b1, 8'hCD, "R6 call opcode");
        check_int(1'b1, "R9 int high mid-sequence");
        checks++;
        if (bus_doe !== 1'b0) begin
            failures++;
            $display("FAIL R7 drive between reads, bus_doe=%0b expected 0", bus_doe);
        end
        mem_read(1'b1, 8'h38, "R6 call low byte line1");
        check_int(1'b1, "R9 int high before high byte");
        mem_read(1'b1, 8'h12, "R6 call high byte line1");
        check_int(1'b0, "R3 line2 pending after call");
        ack_cycle(1'b1, 8'hCD, "R6 second call opcode");
        mem_read(1'b1, 8'h40, "R6 call low byte line2");
        mem_read(1'b1, 8'h12, "R6 call high byte line2");
        mem_read(1'b0, 8'h00, "R7 stray read not driven");
        set_irq(4'b0000);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule